// File: doc/BRIEF.md
# Cache miss status holding entry

This block is a single miss-tracking slot for a non-blocking cache. The parent cache allocates it when a line misses. At allocation the block captures a block-aligned address, a secure-space bit, an order number, an allocate-on-fill hint and, optionally, the first waiting request. More requests that hit the same line while the miss is open are queued behind the first. The parent finds the open slot for a line through the address match output.

The parent marks the slot in service when the downstream request goes out. At that point it states whether the fill will arrive dirty and owned, which also means writable. From then on, a request that needs a writable copy the fill will not grant is parked on a second, deferred queue. Snooped invalidates and reads that arrive while the slot waits for data are remembered. When the line would have been lost, queued upgrade and store-conditional requests are rewritten.

After the fill, the parent pops primary requests one at a time. Once the primary queue is empty, a promote command moves the deferred requests to the primary queue and drops the slot out of service so that it can be issued again.

Top module: `miss_entry`

## Requirements
- R1: After reset the slot is invalid and holds no requests. `valid_o`, `match_o`, `has_tgt_o`, `in_service_o` and `num_tgt_o` are all 0.
- R2: `alloc_i` on an invalid slot makes it valid on the next cycle and stores the address, secure bit, order number and fill hint. `match_o` is 1 exactly when the slot is valid, the secure bits are equal, and the addresses agree above the OFF_W block-offset bits.
- R3: Commands are encoded as read=0, read-exclusive=1, upgrade=2, store-conditional=3, failed store-conditional=4 and write=5. Commands 1, 2, 3 and 5 need a writable copy. Sources are encoded as CPU=0, snoop=1 and prefetcher=2. A request that needs a writable copy goes to the deferred queue when it arrives while the slot is in service with pending-modified clear. Every other request goes to the primary queue.
- R4: The primary queue has a needs-writable flag, set when a command 1, 2, 3 or 5 enters it, and a has-upgrade flag, set when a command 2 or 3 enters it. Both flags are cleared on allocation and on deallocation.
- R5: A snooped invalidate sets post-invalidate, and a snooped read sets post-downgrade, only while the slot is in service. Snoops seen outside service are ignored.
- R6: The pending-modified, post-invalidate and post-downgrade outputs read 0 when the slot is not in service. `flag_err_o` is 1 whenever `flag_rd_i` is 1 while the slot is not in service.
- R7: `line_lost_i` rewrites every queued upgrade (2) to read-exclusive (1) and every store-conditional (3) to failed (4), and it clears has-upgrade.
- R8: `num_tgt_o` is the sum of the two queue occupancies. `has_tgt_o` and the head outputs refer only to the primary queue, which pops in arrival order.
- R9: `fwd_nr_o` is 1 exactly when the slot holds one request in total, that request is at the primary head, its source is CPU and it needs no response.
- R10: `promote_i` with an empty primary queue and a non-empty deferred queue moves all deferred requests, in order and with their flags, to the primary queue and clears in-service. In any other state `promote_i` is ignored.
- R11: A request whose chosen queue is full, or that arrives while the slot is neither valid nor being allocated, is refused. `add_err_o` flags the refusal in the same cycle and the occupancy does not change.
- R12: `dealloc_i` invalidates the slot and clears both queues and all flags in one cycle. It takes priority over every other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_i | input | 1 | Allocate the slot |
| alloc_addr_i | input | ADDR_W | Miss address |
| alloc_secure_i | input | 1 | Secure-space bit of the miss |
| alloc_order_i | input | ORD_W | Order number of the miss |
| alloc_fill_i | input | 1 | Allocate-on-fill hint |
| dealloc_i | input | 1 | Free the slot |
| lookup_addr_i | input | ADDR_W | Address to compare |
| lookup_secure_i | input | 1 | Secure bit to compare |
| tgt_valid_i | input | 1 | Enqueue a request |
| tgt_cmd_i | input | 3 | Request command |
| tgt_src_i | input | 2 | Request source |
| tgt_order_i | input | ORD_W | Request order number |
| tgt_hnd_i | input | HND_W | Request handle |
| tgt_resp_i | input | 1 | Request needs a response |
| tgt_mark_i | input | 1 | Request marked an upstream slot pending |
| issue_i | input | 1 | Downstream request issued |
| issue_pmod_i | input | 1 | Fill will be dirty, owned and writable |
| snoop_inv_i | input | 1 | Snooped invalidate |
| snoop_rd_i | input | 1 | Snooped read |
| line_lost_i | input | 1 | Line would be invalid: rewrite upgrades |
| pop_i | input | 1 | Pop the primary head |
| promote_i | input | 1 | Move deferred requests to primary |
| flag_rd_i | input | 1 | Parent reads the service flags |
| valid_o | output | 1 | Slot allocated |
| match_o | output | 1 | Lookup hits this slot |
| order_o | output | ORD_W | Stored order number |
| fill_alloc_o | output | 1 | Stored fill hint |
| in_service_o | output | 1 | Downstream request outstanding |
| pend_mod_o | output | 1 | Pending-modified |
| post_inv_o | output | 1 | Invalidate snooped while waiting |
| post_dg_o | output | 1 | Read snooped while waiting |
| flag_err_o | output | 1 | Flags read out of service |
| needs_wr_o | output | 1 | Primary needs-writable flag |
| has_upg_o | output | 1 | Primary has-upgrade flag |
| num_tgt_o | output | CW+1 | Total queued requests |
| has_tgt_o | output | 1 | Primary queue non-empty |
| prim_full_o | output | 1 | Primary queue full |
| def_full_o | output | 1 | Deferred queue full |
| add_err_o | output | 1 | Enqueue refused |
| fwd_nr_o | output | 1 | Single CPU request needing no response |
| head_cmd_o | output | 3 | Primary head command |
| head_src_o | output | 2 | Primary head source |
| head_order_o | output | ORD_W | Primary head order |
| head_hnd_o | output | HND_W | Primary head handle |
| head_resp_o | output | 1 | Primary head needs response |
| head_mark_o | output | 1 | Primary head marked-pending bit |

## Verification
The bench goes after the routing of writable-needing requests both before and after issue, and with pending-modified set and clear. A design that ignored pending-modified would either strand requests in the deferred queue or serve them from a fill that cannot satisfy them.

It rewrites upgrades and store-conditionals that are already queued behind a plain read. A design that rewrote only the head, or that left has-upgrade set, would be exposed by the popped commands.

It fills the primary queue and then offers one more request. A design that overwrote a queued entry would show a changed count or a wrong head order.

It promotes after a drain. A promotion that reversed the order, or that left the slot in service, would be caught. It also checks that snoops arriving outside service leave no trace.

// File: rtl/miss_entry_pkg.sv
`timescale 1ns/1ps
package miss_entry_pkg;
  typedef enum logic [2:0] {
    CMD_RD  = 3'd0,
    CMD_RDX = 3'd1,
    CMD_UPG = 3'd2,
    CMD_SC  = 3'd3,
    CMD_SCF = 3'd4,
    CMD_WR  = 3'd5
  } cmd_e;

  typedef enum logic [1:0] {
    SRC_CPU = 2'd0,
    SRC_SNP = 2'd1,
    SRC_PF  = 2'd2
  } src_e;

  function automatic logic cmd_needs_wr(input logic [2:0] c);
    return (c == CMD_RDX) || (c == CMD_UPG) || (c == CMD_SC) || (c == CMD_WR);
  endfunction

  function automatic logic cmd_is_upg(input logic [2:0] c);
    return (c == CMD_UPG) || (c == CMD_SC);
  endfunction
endpackage

// File: rtl/miss_tgt_fifo.sv
`timescale 1ns/1ps
// Circular request queue; cmd field sits in bits [2:0]. DEPTH must be a power of two.
module miss_tgt_fifo
  import miss_entry_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     push_i,
  input  logic [W-1:0]             din_i,
  input  logic                     pop_i,
  input  logic                     cvt_i,
  input  logic                     load_i,
  input  logic [DEPTH-1:0][W-1:0]  ld_mem_i,
  input  logic [AW-1:0]            ld_rd_i,
  input  logic [CW-1:0]            ld_cnt_i,
  output logic [DEPTH-1:0][W-1:0]  mem_o,
  output logic [AW-1:0]            rd_o,
  output logic [CW-1:0]            cnt_o,
  output logic [W-1:0]             head_o,
  output logic                     full_o,
  output logic                     empty_o
);
  logic [DEPTH-1:0][W-1:0] mem_q;
  logic [AW-1:0] rd_q, rd_base, wr_ptr;
  logic [CW-1:0] cnt_q, cnt_base;

  assign rd_base  = clr_i ? '0 : rd_q;
  assign cnt_base = clr_i ? '0 : cnt_q;
  assign wr_ptr   = rd_base + cnt_base[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      rd_q  <= ld_rd_i;
      cnt_q <= ld_cnt_i;
    end else begin
      rd_q  <= rd_base + AW'(pop_i);
      cnt_q <= cnt_base + CW'(push_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (load_i) begin
      mem_q <= ld_mem_i;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (cvt_i) begin
          if (mem_q[i][2:0] == CMD_UPG) mem_q[i][2:0] <= CMD_RDX;
          else if (mem_q[i][2:0] == CMD_SC) mem_q[i][2:0] <= CMD_SCF;
        end
      end
      if (push_i) mem_q[wr_ptr] <= din_i;
    end
  end

  assign mem_o   = mem_q;
  assign rd_o    = rd_q;
  assign cnt_o   = cnt_q;
  assign head_o  = mem_q[rd_q];
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);

  assert_no_overflow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !clr_i) |-> !full_o);
  assert_no_underflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !clr_i) |-> !empty_o);
endmodule

// File: rtl/miss_q_flags.sv
`timescale 1ns/1ps
module miss_q_flags
  import miss_entry_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       set_i,
  input  logic [2:0] cmd_i,
  input  logic       cvt_i,
  input  logic       ld_i,
  input  logic       ld_nw_i,
  input  logic       ld_hu_i,
  output logic       nw_o,
  output logic       hu_o
);
  logic nw_q, hu_q, nw_b, hu_b;

  assign nw_b = clr_i ? 1'b0 : nw_q;
  assign hu_b = clr_i ? 1'b0 : hu_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nw_q <= 1'b0;
      hu_q <= 1'b0;
    end else if (ld_i) begin
      nw_q <= ld_nw_i;
      hu_q <= ld_hu_i;
    end else begin
      nw_q <= nw_b | (set_i & cmd_needs_wr(cmd_i));
      hu_q <= (hu_b & ~cvt_i) | (set_i & cmd_is_upg(cmd_i));
    end
  end

  assign nw_o = nw_q;
  assign hu_o = hu_q;
endmodule

// File: rtl/miss_entry_state.sv
`timescale 1ns/1ps
module miss_entry_state #(
  parameter int ADDR_W = 32,
  parameter int ORD_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic              dealloc_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              secure_i,
  input  logic [ORD_W-1:0]  order_i,
  input  logic              fill_i,
  input  logic              issue_i,
  input  logic              pmod_i,
  input  logic              snp_inv_i,
  input  logic              snp_rd_i,
  input  logic              requeue_i,
  output logic              valid_o,
  output logic              in_svc_o,
  output logic              pmod_o,
  output logic              pinv_o,
  output logic              pdg_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              secure_o,
  output logic [ORD_W-1:0]  order_o,
  output logic              fill_o
);
  logic valid_q, in_svc_q, pmod_q, pinv_q, pdg_q, wipe;

  assign wipe = dealloc_i | alloc_i | requeue_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      in_svc_q <= 1'b0;
      pmod_q   <= 1'b0;
      pinv_q   <= 1'b0;
      pdg_q    <= 1'b0;
      addr_o   <= '0;
      secure_o <= 1'b0;
      order_o  <= '0;
      fill_o   <= 1'b0;
    end else if (wipe) begin
      in_svc_q <= 1'b0;
      pmod_q   <= 1'b0;
      pinv_q   <= 1'b0;
      pdg_q    <= 1'b0;
      if (dealloc_i) begin
        valid_q <= 1'b0;
      end else if (alloc_i) begin
        valid_q  <= 1'b1;
        addr_o   <= addr_i;
        secure_o <= secure_i;
        order_o  <= order_i;
        fill_o   <= fill_i;
      end
    end else begin
      if (issue_i && valid_q && !in_svc_q) begin
        in_svc_q <= 1'b1;
        pmod_q   <= pmod_i;
      end
      if (in_svc_q && snp_inv_i) pinv_q <= 1'b1;
      if (in_svc_q && snp_rd_i)  pdg_q  <= 1'b1;
    end
  end

  assign valid_o  = valid_q;
  assign in_svc_o = in_svc_q;
  assign pmod_o   = pmod_q;
  assign pinv_o   = pinv_q;
  assign pdg_o    = pdg_q;

  assert_snoop_in_service_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pinv_q) || $rose(pdg_q)) |-> $past(in_svc_q));
  assert_dealloc_clears_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dealloc_i |=> (!valid_q && !in_svc_q && !pinv_q && !pdg_q));
endmodule

// File: rtl/miss_entry.sv
`timescale 1ns/1ps
module miss_entry
  import miss_entry_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6,
  parameter int ORD_W  = 16,
  parameter int HND_W  = 8,
  parameter int DEPTH  = 4,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  input  logic              alloc_secure_i,
  input  logic [ORD_W-1:0]  alloc_order_i,
  input  logic              alloc_fill_i,
  input  logic              dealloc_i,
  input  logic [ADDR_W-1:0] lookup_addr_i,
  input  logic              lookup_secure_i,
  input  logic              tgt_valid_i,
  input  logic [2:0]        tgt_cmd_i,
  input  logic [1:0]        tgt_src_i,
  input  logic [ORD_W-1:0]  tgt_order_i,
  input  logic [HND_W-1:0]  tgt_hnd_i,
  input  logic              tgt_resp_i,
  input  logic              tgt_mark_i,
  input  logic              issue_i,
  input  logic              issue_pmod_i,
  input  logic              snoop_inv_i,
  input  logic              snoop_rd_i,
  input  logic              line_lost_i,
  input  logic              pop_i,
  input  logic              promote_i,
  input  logic              flag_rd_i,
  output logic              valid_o,
  output logic              match_o,
  output logic [ORD_W-1:0]  order_o,
  output logic              fill_alloc_o,
  output logic              in_service_o,
  output logic              pend_mod_o,
  output logic              post_inv_o,
  output logic              post_dg_o,
  output logic              flag_err_o,
  output logic              needs_wr_o,
  output logic              has_upg_o,
  output logic [CW:0]       num_tgt_o,
  output logic              has_tgt_o,
  output logic              prim_full_o,
  output logic              def_full_o,
  output logic              add_err_o,
  output logic              fwd_nr_o,
  output logic [2:0]        head_cmd_o,
  output logic [1:0]        head_src_o,
  output logic [ORD_W-1:0]  head_order_o,
  output logic [HND_W-1:0]  head_hnd_o,
  output logic              head_resp_o,
  output logic              head_mark_o
);
  localparam int AW    = $clog2(DEPTH);
  localparam int ORD_L = 3;
  localparam int HND_L = ORD_L + ORD_W;
  localparam int SRC_L = HND_L + HND_W;
  localparam int RSP_B = SRC_L + 2;
  localparam int MRK_B = RSP_B + 1;
  localparam int TW    = MRK_B + 1;
  localparam logic [ADDR_W-1:0] TAG_MASK = {ADDR_W{1'b1}} << OFF_W;

  logic valid_q, in_svc, pmod_q, pinv_q, pdg_q, sec_q;
  logic [ADDR_W-1:0] addr_q;
  logic alloc_ok, clr_all, to_def, add_ok, pop_ok, prom_ok, lost_ok;
  logic [TW-1:0] din, p_head, d_head;
  logic [DEPTH-1:0][TW-1:0] p_mem, d_mem;
  logic [AW-1:0] p_rd, d_rd;
  logic [CW-1:0] p_cnt, d_cnt;
  logic p_full, p_empty, d_full, d_empty;
  logic p_nw, p_hu, d_nw, d_hu;

  assign alloc_ok = alloc_i && !valid_q && !dealloc_i;
  assign clr_all  = dealloc_i || alloc_ok;
  assign lost_ok  = line_lost_i && valid_q && !clr_all;
  assign to_def   = in_svc && !pmod_q && cmd_needs_wr(tgt_cmd_i) && !alloc_ok;
  assign add_ok   = tgt_valid_i && !dealloc_i && (valid_q || alloc_ok) &&
                    !(alloc_ok ? 1'b0 : (to_def ? d_full : p_full));
  assign pop_ok   = pop_i && !p_empty && !clr_all;
  assign prom_ok  = promote_i && p_empty && !d_empty && !tgt_valid_i && !clr_all;
  assign din      = {tgt_mark_i, tgt_resp_i, tgt_src_i, tgt_hnd_i, tgt_order_i, tgt_cmd_i};

  miss_entry_state #(.ADDR_W(ADDR_W), .ORD_W(ORD_W)) u_state (
    .clk_i, .rst_ni,
    .alloc_i(alloc_ok), .dealloc_i,
    .addr_i(alloc_addr_i & TAG_MASK), .secure_i(alloc_secure_i),
    .order_i(alloc_order_i), .fill_i(alloc_fill_i),
    .issue_i, .pmod_i(issue_pmod_i),
    .snp_inv_i(snoop_inv_i), .snp_rd_i(snoop_rd_i), .requeue_i(prom_ok),
    .valid_o(valid_q), .in_svc_o(in_svc), .pmod_o(pmod_q),
    .pinv_o(pinv_q), .pdg_o(pdg_q),
    .addr_o(addr_q), .secure_o(sec_q), .order_o, .fill_o(fill_alloc_o)
  );

  miss_tgt_fifo #(.W(TW), .DEPTH(DEPTH)) u_prim (
    .clk_i, .rst_ni, .clr_i(clr_all),
    .push_i(add_ok && !to_def), .din_i(din), .pop_i(pop_ok), .cvt_i(lost_ok),
    .load_i(prom_ok), .ld_mem_i(d_mem), .ld_rd_i(d_rd), .ld_cnt_i(d_cnt),
    .mem_o(p_mem), .rd_o(p_rd), .cnt_o(p_cnt), .head_o(p_head),
    .full_o(p_full), .empty_o(p_empty)
  );

  miss_tgt_fifo #(.W(TW), .DEPTH(DEPTH)) u_def (
    .clk_i, .rst_ni, .clr_i(clr_all || prom_ok),
    .push_i(add_ok && to_def), .din_i(din), .pop_i(1'b0), .cvt_i(lost_ok),
    .load_i(1'b0), .ld_mem_i(p_mem), .ld_rd_i(p_rd), .ld_cnt_i(p_cnt),
    .mem_o(d_mem), .rd_o(d_rd), .cnt_o(d_cnt), .head_o(d_head),
    .full_o(d_full), .empty_o(d_empty)
  );

  miss_q_flags u_pflags (
    .clk_i, .rst_ni, .clr_i(clr_all), .set_i(add_ok && !to_def), .cmd_i(tgt_cmd_i),
    .cvt_i(lost_ok), .ld_i(prom_ok), .ld_nw_i(d_nw), .ld_hu_i(d_hu),
    .nw_o(p_nw), .hu_o(p_hu)
  );

  miss_q_flags u_dflags (
    .clk_i, .rst_ni, .clr_i(clr_all || prom_ok), .set_i(add_ok && to_def),
    .cmd_i(tgt_cmd_i), .cvt_i(lost_ok), .ld_i(1'b0), .ld_nw_i(1'b0), .ld_hu_i(1'b0),
    .nw_o(d_nw), .hu_o(d_hu)
  );

  assign valid_o      = valid_q;
  assign match_o      = valid_q && (sec_q == lookup_secure_i) &&
                        (((lookup_addr_i ^ addr_q) & TAG_MASK) == '0);
  assign in_service_o = in_svc;
  assign pend_mod_o   = in_svc & pmod_q;
  assign post_inv_o   = in_svc & pinv_q;
  assign post_dg_o    = in_svc & pdg_q;
  assign flag_err_o   = flag_rd_i & ~in_svc;
  assign needs_wr_o   = p_nw;
  assign has_upg_o    = p_hu;
  assign num_tgt_o    = (CW+1)'(p_cnt) + (CW+1)'(d_cnt);
  assign has_tgt_o    = !p_empty;
  assign prim_full_o  = p_full;
  assign def_full_o   = d_full;
  assign add_err_o    = tgt_valid_i && !dealloc_i && !add_ok;
  assign head_cmd_o   = p_head[2:0];
  assign head_order_o = p_head[HND_L-1:ORD_L];
  assign head_hnd_o   = p_head[SRC_L-1:HND_L];
  assign head_src_o   = p_head[RSP_B-1:SRC_L];
  assign head_resp_o  = p_head[RSP_B];
  assign head_mark_o  = p_head[MRK_B];
  assign fwd_nr_o     = (num_tgt_o == (CW+1)'(1)) && !p_empty &&
                        (head_src_o == SRC_CPU) && !head_resp_o;

  logic unused_dhead;
  assign unused_dhead = ^d_head;

  assert_promote_moves_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prom_ok |=> (d_cnt == '0) && (p_cnt == $past(d_cnt)) && !in_svc);
  assert_count_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    num_tgt_o <= (CW+1)'(2 * DEPTH));
endmodule

// File: tb/miss_entry_tb.sv
`timescale 1ns/1ps
module miss_entry_tb;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  always #2.5 clk_i = ~clk_i;

  logic alloc_i, alloc_secure_i, alloc_fill_i, dealloc_i, lookup_secure_i;
  logic [31:0] alloc_addr_i, lookup_addr_i;
  logic [15:0] alloc_order_i, tgt_order_i, order_o, head_order_o;
  logic tgt_valid_i, tgt_resp_i, tgt_mark_i, issue_i, issue_pmod_i;
  logic [2:0] tgt_cmd_i, head_cmd_o;
  logic [1:0] tgt_src_i, head_src_o;
  logic [7:0] tgt_hnd_i, head_hnd_o;
  logic snoop_inv_i, snoop_rd_i, line_lost_i, pop_i, promote_i, flag_rd_i;
  logic valid_o, match_o, fill_alloc_o, in_service_o, pend_mod_o, post_inv_o, post_dg_o;
  logic flag_err_o, needs_wr_o, has_upg_o, has_tgt_o, prim_full_o, def_full_o;
  logic add_err_o, fwd_nr_o, head_resp_o, head_mark_o;
  logic [3:0] num_tgt_o;

  miss_entry u_dut (.*);

  int errs = 0, checks = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    alloc_i = 0; alloc_secure_i = 0; alloc_fill_i = 0; alloc_addr_i = 0; alloc_order_i = 0;
    dealloc_i = 0; tgt_valid_i = 0; tgt_cmd_i = 0; tgt_src_i = 0; tgt_order_i = 0;
    tgt_hnd_i = 0; tgt_resp_i = 0; tgt_mark_i = 0; issue_i = 0; issue_pmod_i = 0;
    snoop_inv_i = 0; snoop_rd_i = 0; line_lost_i = 0; pop_i = 0; promote_i = 0; flag_rd_i = 0;
  endtask

  task automatic step();
    @(posedge clk_i); #1; idle();
  endtask

  task automatic set_tgt(logic [2:0] c, logic [1:0] s, logic [7:0] h, logic r);
    tgt_valid_i = 1; tgt_cmd_i = c; tgt_src_i = s; tgt_hnd_i = h; tgt_resp_i = r;
    tgt_order_i = 16'(h) + 16'd100; tgt_mark_i = h[0];
  endtask

  task automatic do_alloc(logic [31:0] a, logic [2:0] c, logic [1:0] s, logic [7:0] h, logic r);
    alloc_i = 1; alloc_addr_i = a; alloc_order_i = 16'd7; alloc_fill_i = 1;
    set_tgt(c, s, h, r); step();
  endtask

  // {lookup address, secure bit, expected match}
  localparam logic [33:0] VECS [0:5] = '{
    {32'h1000_0040, 1'b0, 1'b1},
    {32'h1000_007F, 1'b0, 1'b1},
    {32'h1000_0080, 1'b0, 1'b0},
    {32'h1000_0040, 1'b1, 1'b0},
    {32'h0000_0040, 1'b0, 1'b0},
    {32'h1000_0000, 1'b0, 1'b0}
  };

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    idle(); lookup_addr_i = 0; lookup_secure_i = 0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    // R1 reset state
    chk("R1 valid", valid_o, 0); chk("R1 num", num_tgt_o, 0);
    chk("R1 has_tgt", has_tgt_o, 0); chk("R1 match", match_o, 0);
    chk("R1 in_service", in_service_o, 0);

    // R2 allocation with first request
    do_alloc(32'h1000_0040, 3'd0, 2'd0, 8'd1, 1);
    chk("R2 valid", valid_o, 1); chk("R2 order", order_o, 7); chk("R2 fill", fill_alloc_o, 1);
    chk("R8 num after alloc", num_tgt_o, 1); chk("R8 head hnd", head_hnd_o, 1);
    chk("R8 head order", head_order_o, 101); chk("R8 head mark", head_mark_o, 1);
    chk("R4 needs_wr read", needs_wr_o, 0); chk("R9 fwd needs resp", fwd_nr_o, 0);
    for (int i = 0; i < 6; i++) begin
      lookup_addr_i = VECS[i][33:2]; lookup_secure_i = VECS[i][1]; #1;
      chk($sformatf("R2 match vec %0d", i), match_o, VECS[i][0]);
    end

    // R3/R4 upgrade before issue goes primary
    set_tgt(3'd2, 2'd0, 8'd2, 1); step();
    chk("R3 num upg", num_tgt_o, 2); chk("R4 needs_wr", needs_wr_o, 1);
    chk("R4 has_upg", has_upg_o, 1); chk("R8 head keeps", head_hnd_o, 1);

    // R6 flags out of service
    flag_rd_i = 1; #1;
    chk("R6 flag_err", flag_err_o, 1); chk("R6 pend_mod gated", pend_mod_o, 0);
    idle();
    // R5 snoop outside service ignored
    snoop_inv_i = 1; step();
    issue_i = 1; issue_pmod_i = 0; step();
    chk("R5 in_service", in_service_o, 1); chk("R5 inv ignored", post_inv_o, 0);
    flag_rd_i = 1; #1; chk("R6 no err in service", flag_err_o, 0); idle();

    // R3 writable need after issue without pending-modified -> deferred
    set_tgt(3'd1, 2'd0, 8'd3, 1); step();
    chk("R3 num deferred", num_tgt_o, 3); chk("R3 head unchanged", head_hnd_o, 1);
    set_tgt(3'd0, 2'd0, 8'd4, 1); step();
    chk("R8 num sum", num_tgt_o, 4);
    snoop_rd_i = 1; step();
    chk("R5 post_dg", post_dg_o, 1); chk("R5 post_inv clear", post_inv_o, 0);

    // R7 conversion of queued upgrade
    line_lost_i = 1; step();
    chk("R7 has_upg cleared", has_upg_o, 0); chk("R7 needs_wr kept", needs_wr_o, 1);
    chk("R8 head cmd", head_cmd_o, 0);
    pop_i = 1; step();
    chk("R7 upg->rdx", head_cmd_o, 1); chk("R8 fifo order 2", head_hnd_o, 2);
    pop_i = 1; step();
    chk("R8 fifo order 4", head_hnd_o, 4);
    pop_i = 1; step();
    chk("R8 has_tgt only primary", has_tgt_o, 0); chk("R8 num deferred left", num_tgt_o, 1);

    // R10 promotion
    promote_i = 1; step();
    chk("R10 head", head_hnd_o, 3); chk("R10 cmd", head_cmd_o, 1);
    chk("R10 has_tgt", has_tgt_o, 1); chk("R10 num", num_tgt_o, 1);
    chk("R10 in_service cleared", in_service_o, 0); chk("R10 needs_wr", needs_wr_o, 1);
    pop_i = 1; step();
    chk("R8 empty", num_tgt_o, 0);
    promote_i = 1; step();
    chk("R10 ignored when empty", num_tgt_o, 0);
    dealloc_i = 1; step();
    lookup_addr_i = 32'h1000_0040; lookup_secure_i = 0; #1;
    chk("R12 valid", valid_o, 0); chk("R12 match", match_o, 0);

    // R11 full primary
    do_alloc(32'h2000_0000, 3'd0, 2'd0, 8'd10, 1);
    for (int h = 11; h < 14; h++) begin set_tgt(3'd0, 2'd0, 8'(h), 1); step(); end
    chk("R11 full", prim_full_o, 1); chk("R11 num 4", num_tgt_o, 4);
    set_tgt(3'd0, 2'd0, 8'd14, 1); #1;
    chk("R11 add_err", add_err_o, 1); step();
    chk("R11 num unchanged", num_tgt_o, 4);
    issue_i = 1; issue_pmod_i = 1; step();
    chk("R6 pend_mod", pend_mod_o, 1);
    set_tgt(3'd1, 2'd0, 8'd15, 1); #1;
    chk("R3 pmod routes primary full", add_err_o, 1); chk("R3 def not full", def_full_o, 0);
    step();
    pop_i = 1; step();
    set_tgt(3'd1, 2'd0, 8'd15, 1); step();
    chk("R3 pmod primary", prim_full_o, 1); chk("R3 num", num_tgt_o, 4);
    for (int k = 0; k < 3; k++) begin pop_i = 1; step(); end
    chk("R3 rdx at head", head_hnd_o, 15);
    snoop_inv_i = 1; step();
    chk("R5 post_inv", post_inv_o, 1);
    dealloc_i = 1; step();
    chk("R12 in_service", in_service_o, 0); chk("R12 num", num_tgt_o, 0);
    chk("R12 flags", needs_wr_o, 0);
    set_tgt(3'd0, 2'd0, 8'd50, 1); #1;
    chk("R11 refused when invalid", add_err_o, 1); step();
    chk("R11 no enqueue invalid", num_tgt_o, 0);

    // R7 store-conditional conversion
    do_alloc(32'h3000_0000, 3'd3, 2'd0, 8'd20, 1);
    chk("R4 has_upg sc", has_upg_o, 1);
    line_lost_i = 1; step();
    chk("R7 sc->fail", head_cmd_o, 4); chk("R7 sc has_upg", has_upg_o, 0);
    dealloc_i = 1; step();

    // R9 forward without response
    do_alloc(32'h4000_0000, 3'd5, 2'd0, 8'd30, 0);
    chk("R9 fwd single", fwd_nr_o, 1); chk("R9 src", head_src_o, 0); chk("R9 resp", head_resp_o, 0);
    set_tgt(3'd0, 2'd2, 8'd31, 1); step();
    chk("R9 two targets", fwd_nr_o, 0);
    dealloc_i = 1; step();
    do_alloc(32'h4000_0000, 3'd5, 2'd2, 8'd32, 0);
    chk("R9 prefetch source", fwd_nr_o, 0);
    dealloc_i = 1; step();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule